// File: doc/BRIEF.md
# Single-Channel Pixel Color Matrix Unit

This unit sits in a display pipeline just ahead of the gamma lookup. It applies a 3x3 color matrix to RGB pixels that belong to one chosen display output channel. Pixels from every other channel, and all pixels while the matrix is off, leave the unit unchanged. All pixels, transformed or not, take the same fixed two-cycle path. Pixels of different channels can therefore be interleaved freely on one stream, and they leave in the order they arrived.

A small write-only register port loads three coefficient words, one per source color, and one channel-select word. Each coefficient is a 10-bit sign-magnitude fraction with no integer bits. Register writes go into a staging copy. The whole staged set becomes active together on a frame-start strobe, so a frame never sees a mix of old and new settings.

For the chosen channel, each output component is the signed sum of three products. The sum is rounded to nearest and clamped to the 8-bit range.

Top module: `colorMatrixUnit`

## Requirements
- R1: During reset and on the first cycles after it, `outValid` and `outPix` are 0. Reset sets the active channel select to 0, so after reset the matrix is disabled until a select is written and applied.
- R2: An input pixel with `inValid` high appears on the outputs exactly two clock cycles later, with `outValid` high and `outChan` equal to its `inChan`. `outValid` is never high without such an input.
- R3: A valid pixel whose channel is not the selected one leaves with `outPix` equal to its `inPix`.
- R4: The select field is one-based. A select of 0 disables the matrix. A select of n+1 transforms channel n only. A select greater than `NUM_CHAN` transforms no channel.
- R5: Each coefficient field is 10 bits. Bit 9 is the sign (1 means negative). Bits 8:0 give the magnitude in 512ths, so the largest magnitude is 511/512.
- R6: Register address 2 holds the coefficients applied to the red input, address 1 those for the green input, and address 0 those for the blue input. In each of these words, bits 9:0 feed the red output, bits 19:10 the green output and bits 29:20 the blue output. Address 3 holds the select in bits 2:0.
- R7: Pixels are packed as red in bits 23:16, green in 15:8 and blue in 7:0. A transformed output component is floor((sum over sources of coef*input + 256) / 512).
- R8: A transformed component below 0 leaves as 0. One above 255 leaves as 255.
- R9: Register writes have no effect on pixels until a `frameStart` pulse. On that pulse, all staged coefficients and the select become active together for pixels that enter after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Register write data |
| frameStart | input | 1 | Makes the staged settings active |
| inValid | input | 1 | Input pixel valid |
| inChan | input | CHAN_W (2) | Display channel of the input pixel |
| inPix | input | 24 | Input pixel, R/G/B packed |
| outValid | output | 1 | Output pixel valid |
| outChan | output | CHAN_W (2) | Display channel of the output pixel |
| outPix | output | 24 | Output pixel, R/G/B packed |

## Verification
The hardest case to reach from the ports is the boundary between staged and active settings. Settings that are written but not yet applied must leave the pixel stream untouched. Pixels that follow an apply must use the whole new set at once. The stimulus writes a new matrix and select and streams pixels on the chosen channel before pulsing `frameStart`, then streams again after the pulse. A long mixed-channel run with back-to-back pixels and gaps repeats this in the middle of traffic, so that in-flight pixels straddle a settings change. Clamping at both ends is forced with matrices of all-positive and all-negative near-unity coefficients. Out-of-range selects are also applied and checked.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int PIX_W      = 8;
  localparam int COEF_W     = 10;
  localparam int FRAC_W     = 9;
  localparam int REG_W      = 32;
  localparam int REG_ADDR_W = 2;
  localparam int NUM_COMP   = 3;
  localparam logic [REG_ADDR_W-1:0] ADDR_SEL = 2'd3;

  typedef logic [COEF_W-1:0] coef_t;
  // index [source color][destination color], color 0 = red, 1 = green, 2 = blue
  typedef coef_t [NUM_COMP-1:0][NUM_COMP-1:0] coefMat_t;

  typedef struct packed {
    logic     matOn;
    coefMat_t coef;
  } cmxCtl_t;
endpackage

// File: rtl/cmxCtrl.sv
module cmxCtrl
  import cmx_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int CHAN_W   = 2,
  parameter int SEL_W    = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]      regWrData,
  input  logic                  frameStart,
  output cmxCtl_t               ctl,
  output logic [CHAN_W-1:0]     matChan,
  output logic [SEL_W-1:0]      actSel
);
  coefMat_t         stgCoef;
  coefMat_t         actCoef;
  logic [SEL_W-1:0] stgSel;

  wire unusedData = ^regWrData[REG_W-1:NUM_COMP*COEF_W];

  // staging copy, written by the host at any time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgCoef <= '0;
      stgSel  <= '0;
    end else if (regWrEn) begin
      for (int s = 0; s < NUM_COMP; s++) begin
        if (regAddr == REG_ADDR_W'(NUM_COMP - 1 - s)) begin
          for (int d = 0; d < NUM_COMP; d++) begin
            stgCoef[s][d] <= regWrData[d*COEF_W +: COEF_W];
          end
        end
      end
      if (regAddr == ADDR_SEL) stgSel <= regWrData[SEL_W-1:0];
    end
  end

  // active copy, swapped as a whole at frame start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCoef <= '0;
      actSel  <= '0;
    end else if (frameStart) begin
      actCoef <= stgCoef;
      actSel  <= stgSel;
    end
  end

  always_comb begin
    ctl.coef  = actCoef;
    ctl.matOn = (actSel != '0) && (actSel <= SEL_W'(NUM_CHAN));
    matChan   = CHAN_W'(actSel - SEL_W'(1));
  end
endmodule

// File: rtl/cmxDatapath.sv
module cmxDatapath
  import cmx_pkg::*;
#(
  parameter int CHAN_W = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cmxCtl_t                   ctl,
  input  logic [CHAN_W-1:0]         matChan,
  input  logic                      inValid,
  input  logic [CHAN_W-1:0]         inChan,
  input  logic [NUM_COMP*PIX_W-1:0] inPix,
  output logic                      outValid,
  output logic [CHAN_W-1:0]         outChan,
  output logic [NUM_COMP*PIX_W-1:0] outPix
);
  localparam int PROD_W = PIX_W + COEF_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam int PIX_MAX = (1 << PIX_W) - 1;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1 << (FRAC_W - 1));

  typedef logic [NUM_COMP-1:0][NUM_COMP-1:0][PROD_W-1:0] prodMat_t;

  function automatic logic [PROD_W-1:0] mulCoef(input coef_t c, input logic [PIX_W-1:0] p);
    logic [PROD_W-1:0] mag;
    mag = PROD_W'(c[FRAC_W-1:0]) * PROD_W'(p);
    return c[COEF_W-1] ? -mag : mag;
  endfunction

  function automatic logic [PIX_W-1:0] clampPix(input logic signed [SUM_W-1:0] v);
    if (v[SUM_W-1]) return '0;
    else if (|v[SUM_W-2:PIX_W]) return PIX_W'(PIX_MAX);
    else return v[PIX_W-1:0];
  endfunction

  prodMat_t prodD, s1Prod;
  logic     hitD, s1Hit, s1Valid;
  logic [CHAN_W-1:0]         s1Chan;
  logic [NUM_COMP*PIX_W-1:0] s1Pix, matPix;

  assign hitD = ctl.matOn && (inChan == matChan);

  always_comb begin
    for (int s = 0; s < NUM_COMP; s++) begin
      for (int d = 0; d < NUM_COMP; d++) begin
        prodD[s][d] = mulCoef(ctl.coef[s][d], inPix[(NUM_COMP-1-s)*PIX_W +: PIX_W]);
      end
    end
  end

  // stage 1: products, sideband
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Chan  <= '0;
      s1Pix   <= '0;
      s1Hit   <= 1'b0;
      s1Prod  <= '0;
    end else begin
      s1Valid <= inValid;
      s1Chan  <= inChan;
      s1Pix   <= inPix;
      s1Hit   <= hitD;
      s1Prod  <= prodD;
    end
  end

  // accumulate, round, clamp for each destination color
  for (genvar d = 0; d < NUM_COMP; d++) begin : g_dst
    logic signed [SUM_W-1:0] acc, shifted;
    always_comb begin
      acc = HALF;
      for (int s = 0; s < NUM_COMP; s++) begin
        acc = acc + SUM_W'($signed(s1Prod[s][d]));
      end
      shifted = acc >>> FRAC_W;
    end
    assign matPix[(NUM_COMP-1-d)*PIX_W +: PIX_W] = clampPix(shifted);
  end

  // stage 2: output register with bypass select
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outChan  <= '0;
      outPix   <= '0;
    end else begin
      outValid <= s1Valid;
      outChan  <= s1Chan;
      outPix   <= s1Hit ? matPix : s1Pix;
    end
  end
endmodule

// File: rtl/colorMatrixUnit.sv
module colorMatrixUnit
  import cmx_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  localparam int CHAN_W  = $clog2(NUM_CHAN),
  localparam int SEL_W   = $clog2(NUM_CHAN + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic [REG_ADDR_W-1:0]     regAddr,
  input  logic [REG_W-1:0]          regWrData,
  input  logic                      frameStart,
  input  logic                      inValid,
  input  logic [CHAN_W-1:0]         inChan,
  input  logic [NUM_COMP*PIX_W-1:0] inPix,
  output logic                      outValid,
  output logic [CHAN_W-1:0]         outChan,
  output logic [NUM_COMP*PIX_W-1:0] outPix
);
  cmxCtl_t           ctlBus;
  logic [CHAN_W-1:0] matChan;
  logic [SEL_W-1:0]  actSel;

  cmxCtrl #(.NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W), .SEL_W(SEL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .frameStart(frameStart),
    .ctl(ctlBus), .matChan(matChan), .actSel(actSel)
  );

  cmxDatapath #(.CHAN_W(CHAN_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .matChan(matChan),
    .inValid(inValid), .inChan(inChan), .inPix(inPix),
    .outValid(outValid), .outChan(outChan), .outPix(outPix)
  );
endmodule

// File: rtl/cmxChecker.sv
module cmxChecker #(
  parameter int CHAN_W = 2,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStart,
  input logic              inValid,
  input logic [CHAN_W-1:0] inChan,
  input logic [23:0]       inPix,
  input logic [SEL_W-1:0]  actSel,
  input logic              outValid,
  input logic [CHAN_W-1:0] outChan,
  input logic [23:0]       outPix
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!outValid && outPix == '0)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2)); // R2

  AST_CHAN_CARRIED: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outChan == $past(inChan, 2)); // R2

  AST_BYPASS_UNCHANGED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ($past(actSel, 2) == '0 ||
      $past(actSel, 2) != SEL_W'($past(inChan, 2)) + SEL_W'(1)))
    |-> outPix == $past(inPix, 2)); // R3

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(frameStart) |-> $stable(actSel)); // R9
endmodule

bind colorMatrixUnit cmxChecker #(.CHAN_W(CHAN_W), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .inValid(inValid),
  .inChan(inChan), .inPix(inPix), .actSel(actSel), .outValid(outValid),
  .outChan(outChan), .outPix(outPix)
);

// File: tb/colorMatrixUnit_tb_top.sv
`timescale 1ns/1ps
module colorMatrixUnit_tb_top;
  localparam int NUM_CHAN = 4;
  localparam int CHAN_W = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, regWrEn = 1'b0, frameStart = 1'b0, inValid = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [CHAN_W-1:0] inChan = '0;
  logic [23:0] inPix = '0;
  logic outValid;
  logic [CHAN_W-1:0] outChan;
  logic [23:0] outPix;

  colorMatrixUnit #(.NUM_CHAN(NUM_CHAN)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .frameStart(frameStart), .inValid(inValid),
    .inChan(inChan), .inPix(inPix), .outValid(outValid), .outChan(outChan),
    .outPix(outPix)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [23:0]       expPixQ[$];
  logic [CHAN_W-1:0] expChanQ[$];
  int                expCycQ[$];
  string             expReqQ[$];

  int stgC[3][3], appC[3][3];
  int stgSel = 0, appSel = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] enc(input int v);
    return (v < 0) ? {1'b1, 9'(-v)} : {1'b0, 9'(v)};
  endfunction

  function automatic logic [23:0] model(input int ch, input logic [23:0] p);
    logic [23:0] r;
    if (appSel == 0 || appSel != ch + 1) return p;
    for (int d = 0; d < 3; d++) begin
      int sum;
      sum = 256;
      for (int s = 0; s < 3; s++) sum += appC[s][d] * int'(p[(2-s)*8 +: 8]);
      sum = sum >>> 9;
      if (sum < 0) sum = 0;
      if (sum > 255) sum = 255;
      r[(2-d)*8 +: 8] = 8'(sum);
    end
    return r;
  endfunction

  task automatic doWrite(input logic [1:0] a, input logic [31:0] dat);
    regWrEn = 1'b1; regAddr = a; regWrData = dat;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // src 0 = red input (addr 2), 1 = green (addr 1), 2 = blue (addr 0)
  task automatic writeCoef(input int src, input int toR, input int toG, input int toB);
    stgC[src][0] = toR; stgC[src][1] = toG; stgC[src][2] = toB;
    doWrite(2'(2 - src), {2'b00, enc(toB), enc(toG), enc(toR)});
  endtask

  task automatic writeSel(input int s);
    stgSel = s;
    doWrite(2'd3, 32'(s));
  endtask

  task automatic applyFrame();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    appC = stgC;
    appSel = stgSel;
  endtask

  task automatic sendPix(input int ch, input logic [23:0] p, input string req);
    inValid = 1'b1; inChan = CHAN_W'(ch); inPix = p;
    expPixQ.push_back(model(ch, p));
    expChanQ.push_back(CHAN_W'(ch));
    expCycQ.push_back(cyc);
    expReqQ.push_back(req);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expPixQ.size() == 0) chk(1'b0, "R2", "unexpected outValid", 1, 0);
      else begin
        logic [23:0] ep; logic [CHAN_W-1:0] ec; int ic; string rq;
        ep = expPixQ.pop_front(); ec = expChanQ.pop_front();
        ic = expCycQ.pop_front(); rq = expReqQ.pop_front();
        chk(outPix == ep, rq, "pixel", int'(outPix), int'(ep));
        chk(outChan == ec, "R2", "channel", int'(outChan), int'(ec));
        chk(cyc == ic + 2, "R2", "latency", cyc - ic, 2);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    lf = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    chk(outPix == '0, "R1", "outPix in reset", int'(outPix), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);

    // R1: matrix disabled after reset even with coefficients applied
    writeCoef(0, 256, 128, -64);
    writeCoef(1, 64, 300, 0);
    writeCoef(2, -32, 10, 511);
    applyFrame();
    sendPix(0, 24'h80_40_20, "R1");
    sendPix(1, 24'hFF_00_FF, "R1");
    repeat (3) @(negedge clk);

    // R9: select staged only, no effect before frame start
    writeSel(1);
    sendPix(0, 24'h64_64_64, "R9");
    sendPix(0, 24'hC8_10_30, "R9");
    repeat (3) @(negedge clk);
    applyFrame();

    // R6 / R5 / R7: single-source pixels expose register and field layout
    sendPix(0, 24'hC8_00_00, "R6");
    sendPix(0, 24'h00_C8_00, "R6");
    sendPix(0, 24'h00_00_C8, "R6");
    sendPix(0, 24'h64_64_64, "R5");
    sendPix(0, 24'h12_F0_7F, "R7");
    // R3: other channels untouched
    sendPix(1, 24'h12_F0_7F, "R3");
    sendPix(2, 24'hC8_00_00, "R3");
    sendPix(3, 24'h00_00_C8, "R3");
    repeat (3) @(negedge clk);

    // R7: rounding at the half point
    writeCoef(0, 256, 0, 0);
    writeCoef(1, 0, 0, 0);
    writeCoef(2, 0, 0, 1);
    applyFrame();
    sendPix(0, 24'h01_00_FF, "R7");
    sendPix(0, 24'h03_00_01, "R7");
    repeat (3) @(negedge clk);

    // R8: clamp high and low
    writeCoef(0, 511, 511, 511);
    writeCoef(1, 511, 511, 511);
    writeCoef(2, 511, 511, 511);
    applyFrame();
    sendPix(0, 24'hFF_FF_FF, "R8");
    sendPix(0, 24'h60_50_40, "R8");
    writeCoef(0, -511, -511, -511);
    writeCoef(1, -511, -511, -511);
    writeCoef(2, -511, -511, -511);
    applyFrame();
    sendPix(0, 24'hFF_FF_FF, "R8");
    sendPix(0, 24'h01_02_03, "R8");
    repeat (3) @(negedge clk);

    // R4: last channel, out-of-range selects, select 0
    writeCoef(0, 100, -200, 300);
    writeCoef(1, -400, 500, 50);
    writeCoef(2, 250, 250, -250);
    writeSel(4);
    applyFrame();
    sendPix(3, 24'hA0_B0_C0, "R4");
    sendPix(0, 24'hA0_B0_C0, "R4");
    writeSel(5);
    applyFrame();
    for (int c = 0; c < 4; c++) sendPix(c, 24'h55_AA_33, "R4");
    writeSel(7);
    applyFrame();
    for (int c = 0; c < 4; c++) sendPix(c, 24'h21_43_65, "R4");
    writeSel(0);
    applyFrame();
    for (int c = 0; c < 4; c++) sendPix(c, 24'h9A_BC_DE, "R4");
    repeat (3) @(negedge clk);

    // mixed traffic with gaps and settings changes in flight
    writeSel(3);
    applyFrame();
    for (int i = 0; i < 400; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      if (i % 97 == 50) begin
        writeCoef(i % 3, int'(lf[8:0]) - 255, int'(lf[17:9]) - 255, int'(lf[26:18]) - 255);
        writeSel(int'(lf[30:28]) % 6);
        applyFrame();
      end
      sendPix(int'(lf[1:0]), lf[31:8], "R7");
      if (lf[2]) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    chk(expPixQ.size() == 0, "R2", "missing outputs", expPixQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule